// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a VLAN identifier, a port member mask and a valid bit. Software never writes the table storage directly. It first posts a data word that carries a member mask. It then posts a command word that carries an opcode, a VLAN identifier, a port number, an optional priority and a start flag. The engine walks the table one entry per clock, applies the operation, and drops its busy flag when the walk is done.

The operations are no-op, flush, load, purge and remove-port. A load reuses an entry whose identifier already matches, or else takes the first free slot. If the table has no match and no free slot, the engine raises a full flag. A separate combinational lookup port takes a VLAN identifier and returns whether it is present, together with its member mask. Other blocks use this port to decide where a frame may be forwarded.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, busy and full are 0, both readback words are 0, and every lookup misses with mask 0.
- R2: Command word layout: opcode in [2:0], start/busy in bit 3, full in bit 4, port in [11:8], VLAN id in [27:16], priority in [30:28], priority enable in bit 31. Readback returns the stored fields, with bit 3 showing live busy and bit 4 showing live full. The priority fields are stored and have no effect on the table.
- R3: A command write with bit 3 set while idle starts the operation. With bit 3 clear, the write only stores the fields and the table is untouched.
- R4: Once started, busy stays high for exactly NUM_ENTRIES+1 cycles and then clears by itself.
- R5: While busy, writes to both the command word and the data word are ignored.
- R6: Data word layout: member mask in [MASK_W-1:0] and a valid flag in bit 11, both readable back. A load (opcode 2) to a new id makes a valid entry with that mask.
- R7: A load to an id that is already present overwrites that entry's mask and uses no second entry, even when the table is full.
- R8: A load that finds neither a match nor a free entry sets full and leaves the table unchanged. Full clears when the next command starts.
- R9: Purge (opcode 3) invalidates only the entry with the matching id, and the freed slot can be reused by a later load.
- R10: Remove-port (opcode 4) clears the given port's bit in every valid entry. A port number at or above MASK_W changes nothing.
- R11: Flush (opcode 1) invalidates every entry.
- R12: No-op (opcode 0) and the unused opcodes 5 to 7 leave the table unchanged.
- R13: The lookup returns hit=1 and the stored mask for a present id, and hit=0 with mask 0 for an absent id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 1 selects the command word, 0 selects the data word |
| wr_data | input | 32 | Write value |
| cmd_rd | output | 32 | Command word readback with live busy and full bits |
| data_rd | output | 32 | Data word readback |
| busy | output | 1 | Operation in progress |
| full | output | 1 | Last load found no room |
| lk_vid | input | 12 | Lookup VLAN id |
| lk_hit | output | 1 | Lookup id present |
| lk_mask | output | MASK_W | Member mask of the looked-up id |

## Verification
The bench builds the engine with NUM_ENTRIES=4 and MASK_W=10. With four entries, the table can be filled in four loads, so the full case and the overwrite-when-full case are reached quickly. The busy window is also short, at five cycles, so its exact length can be counted. A ten-bit mask lets the bench issue a remove-port whose port number lies outside the mask, and a purge followed by a load shows that a freed slot is reused.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W          = 12;
  localparam int PORT_W         = 4;
  localparam int OP_W           = 3;
  localparam int PRIO_W         = 3;
  localparam int CMD_ACT_BIT    = 3;
  localparam int CMD_FULL_BIT   = 4;
  localparam int CMD_PORT_LSB   = 8;
  localparam int CMD_VID_LSB    = 16;
  localparam int CMD_PRIO_LSB   = 28;
  localparam int CMD_PEN_BIT    = 31;
  localparam int DATA_VALID_BIT = 11;
  localparam int MAX_MASK_W     = 16;

  localparam logic [OP_W-1:0] OP_NOP       = 3'd0;
  localparam logic [OP_W-1:0] OP_FLUSH     = 3'd1;
  localparam logic [OP_W-1:0] OP_LOAD      = 3'd2;
  localparam logic [OP_W-1:0] OP_PURGE     = 3'd3;
  localparam logic [OP_W-1:0] OP_DROP_PORT = 3'd4;

  // entry matches a key only when it is valid
  function automatic logic entry_hit(input logic v, input logic [VID_W-1:0] id,
                                     input logic [VID_W-1:0] key);
    return v && (id == key);
  endfunction

  // clear one port bit; ports beyond the mask fall off the top
  function automatic logic [MAX_MASK_W-1:0] drop_bit(input logic [MAX_MASK_W-1:0] m,
                                                     input logic [PORT_W-1:0] p);
    return m & ~(MAX_MASK_W'(1) << p);
  endfunction
endpackage

// File: rtl/vtab_regs.sv
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int MASK_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [31:0]         wr_data,
  input  logic                busy,
  input  logic                full_set,
  output logic                start,
  output logic [OP_W-1:0]     op,
  output logic [VID_W-1:0]    vid,
  output logic [PORT_W-1:0]   port,
  output logic [MASK_W-1:0]   dmask,
  output logic [31:0]         cmd_rd,
  output logic [31:0]         data_rd,
  output logic                full
);
  logic              cmd_wr, data_wr;
  logic [PRIO_W-1:0] prio_q;
  logic              pen_q, dvalid_q;

  assign cmd_wr  = wr_en &&  wr_sel && !busy;
  assign data_wr = wr_en && !wr_sel && !busy;
  assign start   = cmd_wr && wr_data[CMD_ACT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= '0; vid <= '0; port <= '0; prio_q <= '0; pen_q <= 1'b0;
    end else if (cmd_wr) begin
      op     <= wr_data[OP_W-1:0];
      port   <= wr_data[CMD_PORT_LSB +: PORT_W];
      vid    <= wr_data[CMD_VID_LSB +: VID_W];
      prio_q <= wr_data[CMD_PRIO_LSB +: PRIO_W];
      pen_q  <= wr_data[CMD_PEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask <= '0; dvalid_q <= 1'b0;
    end else if (data_wr) begin
      dmask    <= wr_data[MASK_W-1:0];
      dvalid_q <= wr_data[DATA_VALID_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        full <= 1'b0;
    else if (start)    full <= 1'b0;
    else if (full_set) full <= 1'b1;
  end

  always_comb begin
    cmd_rd = '0;
    cmd_rd[OP_W-1:0]                 = op;
    cmd_rd[CMD_ACT_BIT]              = busy;
    cmd_rd[CMD_FULL_BIT]             = full;
    cmd_rd[CMD_PORT_LSB +: PORT_W]   = port;
    cmd_rd[CMD_VID_LSB +: VID_W]     = vid;
    cmd_rd[CMD_PRIO_LSB +: PRIO_W]   = prio_q;
    cmd_rd[CMD_PEN_BIT]              = pen_q;
    data_rd = '0;
    data_rd[MASK_W-1:0]              = dmask;
    data_rd[DATA_VALID_BIT]          = dvalid_q;
  end
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             scan_en,
  output logic             fin_en,
  output logic [IDX_W-1:0] scan_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);
  logic fin_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fin_phase <= 1'b0; scan_idx <= '0;
    end else if (start) begin
      busy <= 1'b1; fin_phase <= 1'b0; scan_idx <= '0;
    end else if (scan_en) begin
      scan_idx <= scan_idx + 1'b1;
      if (scan_idx == LAST) fin_phase <= 1'b1;
    end else if (fin_en) begin
      busy <= 1'b0; fin_phase <= 1'b0;
    end
  end

  assign scan_en = busy && !fin_phase;
  assign fin_en  = busy &&  fin_phase;
endmodule

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int MASK_W      = 10,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scan_en,
  input  logic              fin_en,
  input  logic [IDX_W-1:0]  scan_idx,
  input  logic [OP_W-1:0]   op,
  input  logic [VID_W-1:0]  vid,
  input  logic [PORT_W-1:0] port,
  input  logic [MASK_W-1:0] dmask,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask,
  output logic              full_set
);
  logic              ent_v   [NUM_ENTRIES];
  logic [VID_W-1:0]  ent_vid [NUM_ENTRIES];
  logic [MASK_W-1:0] ent_m   [NUM_ENTRIES];

  logic             matched_q, free_found_q, cur_hit, cur_free, is_load, alloc_en;
  logic [IDX_W-1:0] free_idx_q;

  assign is_load  = (op == OP_LOAD);
  assign cur_hit  = entry_hit(ent_v[scan_idx], ent_vid[scan_idx], vid);
  assign cur_free = !ent_v[scan_idx];
  assign alloc_en = fin_en && is_load && !matched_q &&  free_found_q;
  assign full_set = fin_en && is_load && !matched_q && !free_found_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched_q <= 1'b0; free_found_q <= 1'b0; free_idx_q <= '0;
    end else if (start) begin
      matched_q <= 1'b0; free_found_q <= 1'b0; free_idx_q <= '0;
    end else if (scan_en && is_load) begin
      if (cur_hit) matched_q <= 1'b1;
      if (cur_free && !free_found_q) begin
        free_found_q <= 1'b1;
        free_idx_q   <= scan_idx;
      end
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic              v_q;
    logic [VID_W-1:0]  id_q;
    logic [MASK_W-1:0] m_q;
    logic              sel, own_hit;

    assign sel     = scan_en && (scan_idx == IDX_W'(i));
    assign own_hit = entry_hit(v_q, id_q, vid);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0; id_q <= '0; m_q <= '0;
      end else if (sel) begin
        case (op)
          OP_FLUSH:     v_q <= 1'b0;
          OP_PURGE:     if (own_hit) v_q <= 1'b0;
          OP_LOAD:      if (own_hit) m_q <= dmask;
          OP_DROP_PORT: if (v_q) m_q <= MASK_W'(drop_bit(MAX_MASK_W'(m_q), port));
          default:      ;
        endcase
      end else if (alloc_en && free_idx_q == IDX_W'(i)) begin
        v_q <= 1'b1; id_q <= vid; m_q <= dmask;
      end
    end

    assign ent_v[i]   = v_q;
    assign ent_vid[i] = id_q;
    assign ent_m[i]   = m_q;
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_mask = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entry_hit(ent_v[i], ent_vid[i], lk_vid)) begin
        lk_hit  = 1'b1;
        lk_mask = lk_mask | ent_m[i];
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vtab_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int MASK_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  output logic [31:0]       cmd_rd,
  output logic [31:0]       data_rd,
  output logic              busy,
  output logic              full,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic              start, scan_en, fin_en, full_set;
  logic [IDX_W-1:0]  scan_idx;
  logic [OP_W-1:0]   op;
  logic [VID_W-1:0]  vid;
  logic [PORT_W-1:0] port;
  logic [MASK_W-1:0] dmask;

  vtab_regs #(.MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .full_set(full_set), .start(start), .op(op), .vid(vid),
    .port(port), .dmask(dmask), .cmd_rd(cmd_rd), .data_rd(data_rd), .full(full)
  );

  vtab_seq #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .scan_en(scan_en), .fin_en(fin_en), .scan_idx(scan_idx)
  );

  vtab_store #(.NUM_ENTRIES(NUM_ENTRIES), .MASK_W(MASK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en), .fin_en(fin_en),
    .scan_idx(scan_idx), .op(op), .vid(vid), .port(port), .dmask(dmask),
    .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask), .full_set(full_set)
  );
endmodule

// File: rtl/vtab_chk.sv
module vtab_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int MASK_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              full,
  input logic              scan_en,
  input logic              fin_en,
  input logic [31:0]       cmd_rd,
  input logic [31:0]       data_rd,
  input logic              lk_hit,
  input logic [MASK_W-1:0] lk_mask
);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 2) + 1;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= CNT_W'(NUM_ENTRIES)));
  p_fin_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_en |=> !busy);
  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_en, fin_en}));
  p_full_from_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (cmd_rd[2:0] == 3'd2));
  p_start_clears_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !full);
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({cmd_rd[31:5], cmd_rd[2:0]}));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_rd));
  p_miss_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_mask == '0));
endmodule

bind vlan_cmd_engine vtab_chk #(.NUM_ENTRIES(NUM_ENTRIES), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .full(full), .scan_en(scan_en),
  .fin_en(fin_en), .cmd_rd(cmd_rd), .data_rd(data_rd), .lk_hit(lk_hit), .lk_mask(lk_mask)
);

// File: tb/test_vlan_cmd_engine.sv
module test_vlan_cmd_engine;
  localparam int N  = 4;
  localparam int MW = 10;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   cmd_rd, data_rd;
  logic          busy, full, lk_hit;
  logic [11:0]   lk_vid = '0;
  logic [MW-1:0] lk_mask;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vlan_cmd_engine #(.NUM_ENTRIES(N), .MASK_W(MW)) i_vlan_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_rd(cmd_rd), .data_rd(data_rd), .busy(busy), .full(full),
    .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
  );

  function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic act,
      input logic [11:0] vid, input logic [3:0] port, input logic [2:0] prio, input logic pen);
    return {pen, prio, vid, 4'h0, port, 4'h0, act, op};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  task automatic run(input logic [2:0] op, input logic [11:0] vid, input logic [3:0] port);
    int c;
    wr(1'b1, mk_cmd(op, 1'b1, vid, port, 3'd0, 1'b0));
    wait_idle(c);
  endtask

  task automatic load(input logic [11:0] vid, input logic [MW-1:0] m);
    wr(1'b0, 32'h800 | 32'(m));
    run(3'd2, vid, 4'd0);
  endtask

  task automatic lk(input string req, input logic [11:0] vid, input logic h, input logic [MW-1:0] m);
    lk_vid = vid; #1;
    chk(req, {31'b0, lk_hit}, {31'b0, h});
    chk(req, 32'(lk_mask), 32'(m));
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 full", {31'b0, full}, 0);
    chk("R1 cmd_rd", cmd_rd, 0);
    chk("R1 data_rd", data_rd, 0);
    lk("R1 lookup", 12'd0, 1'b0, '0);
  endtask

  task automatic t_fields;
    wr(1'b1, mk_cmd(3'd2, 1'b0, 12'h123, 4'd5, 3'd6, 1'b1));
    chk("R2 readback", cmd_rd, 32'hE123_0502);
    chk("R3 no start", {31'b0, busy}, 0);
    lk("R3 no load", 12'h123, 1'b0, '0);
    wr(1'b0, 32'h0000_08A5);
    chk("R6 data readback", data_rd, 32'h8A5);
  endtask

  task automatic t_load_timing;
    int c;
    wr(1'b0, 32'h8F3);
    wr(1'b1, mk_cmd(3'd2, 1'b1, 12'd10, 4'd0, 3'd7, 1'b1));
    chk("R2 busy bit", {31'b0, cmd_rd[3]}, 1);
    wait_idle(c);
    chk("R4 busy cycles", 32'(c), N + 1);
    lk("R6 load hit R13", 12'd10, 1'b1, 10'h0F3);
  endtask

  task automatic t_ignore;
    int c;
    wr(1'b0, 32'h801);
    wr(1'b1, mk_cmd(3'd2, 1'b1, 12'd20, 4'd0, 3'd0, 1'b0));
    wr(1'b0, 32'h3FF);
    wr(1'b1, mk_cmd(3'd0, 1'b1, 12'h777, 4'd9, 3'd0, 1'b0));
    chk("R5 cmd kept", 32'(cmd_rd[27:16]), 20);
    chk("R5 data kept", data_rd, 32'h801);
    wait_idle(c);
    lk("R5 load used old data", 12'd20, 1'b1, 10'h001);
  endtask

  task automatic t_overwrite_full;
    load(12'd10, 10'h200);
    lk("R7 overwrite", 12'd10, 1'b1, 10'h200);
    load(12'd30, 10'h010);
    load(12'd40, 10'h3FF);
    chk("R8 not yet full", {31'b0, full}, 0);
    load(12'd50, 10'h055);
    chk("R8 full set", {31'b0, full}, 1);
    chk("R2 full bit", {31'b0, cmd_rd[4]}, 1);
    lk("R8 table unchanged", 12'd50, 1'b0, '0);
    lk("R8 old entry kept", 12'd40, 1'b1, 10'h3FF);
    wr(1'b0, 32'h911);
    wr(1'b1, mk_cmd(3'd2, 1'b1, 12'd10, 4'd0, 3'd0, 1'b0));
    chk("R8 full cleared at start", {30'b0, busy, full}, 32'b10);
    run(3'd0, 12'd0, 4'd0);
    chk("R7 no full on match", {31'b0, full}, 0);
    lk("R7 overwrite when full", 12'd10, 1'b1, 10'h111);
  endtask

  task automatic t_drop_port;
    run(3'd4, 12'd0, 4'd4);
    lk("R10 drop 10", 12'd10, 1'b1, 10'h101);
    lk("R10 drop 20", 12'd20, 1'b1, 10'h001);
    lk("R10 drop 30", 12'd30, 1'b1, 10'h000);
    lk("R10 drop 40", 12'd40, 1'b1, 10'h3EF);
    run(3'd4, 12'd0, 4'd12);
    lk("R10 port out of range", 12'd40, 1'b1, 10'h3EF);
  endtask

  task automatic t_purge;
    run(3'd3, 12'd20, 4'd0);
    lk("R9 purged", 12'd20, 1'b1 ^ 1'b1, '0);
    lk("R9 other kept", 12'd10, 1'b1, 10'h101);
    load(12'd60, 10'h0C0);
    chk("R9 slot reused", {31'b0, full}, 0);
    lk("R9 new entry", 12'd60, 1'b1, 10'h0C0);
  endtask

  task automatic t_nop;
    run(3'd0, 12'd10, 4'd0);
    run(3'd6, 12'd10, 4'd0);
    lk("R12 nop keeps 10", 12'd10, 1'b1, 10'h101);
    lk("R12 nop keeps 60", 12'd60, 1'b1, 10'h0C0);
  endtask

  task automatic t_flush;
    run(3'd1, 12'd0, 4'd0);
    lk("R11 flush 10", 12'd10, 1'b0, '0);
    lk("R11 flush 40", 12'd40, 1'b0, '0);
    lk("R11 flush 60", 12'd60, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_load_timing;
    t_ignore;
    t_overwrite_full;
    t_drop_port;
    t_purge;
    t_nop;
    t_flush;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule